// File: doc/BRIEF.md
# Late-Write Pipelined SRAM with Byte Bypass

This block is a single-clock synchronous memory that behaves like a pipelined SRAM with late write. One rising edge captures the address and every control. On a read, the next rising edge loads the output register. On a write, the data is taken one edge after its address. It is not stored at once. It sits in a holding register, and that register is committed to the array only when the data of the following write arrives.

A read that hits the held address gets the newest value lane by lane. Each lane that the held write enabled comes from the holding register, and every other lane comes from the array. The word is made of nine-bit lanes with active-low per-lane write enables. A sleep input freezes the block. Together with an active-low output enable, it gates the drive qualifier of the read data bus.

Top module: `lw_sram`

## Requirements
- R1: On each rising edge (sleep low) the block samples `sel_n`, `wr_n`, `addr` and `lane_wr_n` together. `sel_n`=1 is a no-operation. `sel_n`=0 with `wr_n`=1 is a read. `sel_n`=0 with `wr_n`=0 is a write.
- R2: A read captured at edge N loads `dout` at edge N+1. `dout_drv` is high after edge N+1 only when sleep is low and `oe_n` is low. After an edge that ends a write or no-operation cycle, `dout_drv` is low.
- R3: For a write whose address is captured at edge N, `din` is sampled at edge N+1.
- R4: Write data is placed in a holding register. It reaches the array only at the edge where the data of the next write is sampled. Reads that follow always see the most recent written value.
- R5: A read whose address equals the held address takes each lane enabled by the held write from the holding register and every other lane from the array.
- R6: Lane i occupies bits 9*i+8 down to 9*i of `din`/`dout`. `lane_wr_n[i]`=0 enables that lane on a write. Disabled lanes keep their old content.
- R7: A write with all `lane_wr_n` bits high still replaces the holding register and commits the previous held write. It changes no stored lane, either by bypass or by its own later commit.
- R8: While `sleep` is high, all other inputs are ignored, `dout_drv` is low, no array or holding-register content changes, and a pending operation is dropped.
- R9: While `oe_n` is high, `dout_drv` is low.
- R10: Two back-to-back reads of the same address with no intervening write give the same `dout` value on consecutive edges.
- R11: Reset leaves `dout_drv` low and the holding register empty. A read after reset returns array content, even for an address written just before reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Sleep: ignore inputs, release bus |
| oe_n | input | 1 | Active-low output enable |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low global write enable |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | LANES | Active-low per-lane write enables |
| din | input | LANES*LANE_W | Write data, one cycle after the address |
| dout | output | LANES*LANE_W | Registered read data |
| dout_drv | output | 1 | Bus drive enable; bus is high-impedance when low |

## Verification
The bench confines random addresses to a handful of words, so reads often land on the held address right after a partial write. A design that bypassed whole words, or ignored the held lane mask, would return stale or foreign lanes there. Directed cases cover three further faults:
- A write with no lanes enabled, followed by a read of the previously held address: a design that skipped the commit on that write would return stale data.
- A reset between a write and its read: a design that kept the holding register valid across reset would return the lost data instead of array data.
- A write issued just before sleep: a design that committed the pending write during sleep would alter contents that must stay frozen.

Back-to-back reads of one address check that `dout` holds still.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    oe_n,
  input  logic                    sel_n,
  input  logic                    wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_drv
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  logic              rd_q, wr_q;
  logic [ADDR_W-1:0] a_q;
  logic [LANES-1:0]  lanes_q;

  logic              hold_v;
  logic [ADDR_W-1:0] hold_a;
  logic [LANES-1:0]  hold_l;
  logic [WORD_W-1:0] hold_d;

  logic              out_vld;
  logic [WORD_W-1:0] dout_q;

  logic [WORD_W-1:0] arr_word, merged;
  logic              hit, commit;

  assign arr_word = mem[a_q];
  assign hit      = hold_v && (hold_a == a_q);
  assign commit   = !sleep && wr_q && hold_v;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*LANE_W +: LANE_W] = (hit && hold_l[i]) ? hold_d[i*LANE_W +: LANE_W]
                                                           : arr_word[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < LANES; i++) begin
        if (hold_l[i]) mem[hold_a][i*LANE_W +: LANE_W] <= hold_d[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      a_q     <= '0;
      lanes_q <= '0;
      hold_v  <= 1'b0;
      hold_a  <= '0;
      hold_l  <= '0;
      hold_d  <= '0;
      out_vld <= 1'b0;
      dout_q  <= '0;
    end else if (sleep) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      rd_q    <= !sel_n && wr_n;
      wr_q    <= !sel_n && !wr_n;
      a_q     <= addr;
      lanes_q <= ~lane_wr_n;
      out_vld <= rd_q;
      if (rd_q) dout_q <= merged;
      if (wr_q) begin
        hold_v <= 1'b1;
        hold_a <= a_q;
        hold_l <= lanes_q;
        hold_d <= din;
      end
    end
  end

  assign dout     = dout_q;
  assign dout_drv = out_vld && !oe_n && !sleep;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sleep,
  input logic                    oe_n,
  input logic                    sel_n,
  input logic                    wr_n,
  input logic [ADDR_W-1:0]       addr,
  input logic [LANES*LANE_W-1:0] dout,
  input logic                    dout_drv
);
  logic rd_req, wr_req;
  assign rd_req = !sleep && !sel_n && wr_n;
  assign wr_req = !sleep && !sel_n && !wr_n;

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_drv);                                                   // R9
  AST_SLEEP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_drv);                                                  // R8
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req ##1 !sleep ##1 (!sleep && !oe_n) |-> dout_drv);                 // R2
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req ##1 1'b1 |=> !dout_drv);                                        // R2
  AST_REPEAT_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req ##1 (rd_req && addr == $past(addr)) ##1 !sleep ##1 1'b1
      |-> $stable(dout));                                                  // R10
endmodule

bind lw_sram lw_sram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n), .sel_n(sel_n),
  .wr_n(wr_n), .addr(addr), .dout(dout), .dout_drv(dout_drv)
);

// File: tb/lw_sram_bench.sv
module lw_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, sleep = 0, oe_n = 0, sel_n = 1, wr_n = 1;
  logic [AW-1:0] addr = '0;
  logic [3:0]    lane_wr_n = 4'hF;
  logic [35:0]   din = '0;
  logic [35:0]   dout;
  logic          dout_drv;

  lw_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(4)) u_lw_sram (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n), .sel_n(sel_n),
    .wr_n(wr_n), .addr(addr), .lane_wr_n(lane_wr_n), .din(din),
    .dout(dout), .dout_drv(dout_drv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;

  logic [35:0] m_mem [DEPTH];
  logic m_rd = 0, m_wr = 0, m_vld = 0, h_v = 0;
  logic [AW-1:0] m_a = '0, h_a = '0;
  logic [3:0] m_l = '0, h_l = '0;
  logic [35:0] h_d = '0, m_out = '0, pend_din = '0, prev_dout = '0;

  function automatic logic [35:0] lane_mask(input logic [3:0] l);
    logic [35:0] m = '0;
    for (int i = 0; i < 4; i++) if (l[i]) m[i*9 +: 9] = 9'h1FF;
    return m;
  endfunction

  function automatic logic [35:0] exp_read(input logic [AW-1:0] a);
    logic [35:0] w = m_mem[a];
    if (h_v && h_a == a) w = (w & ~lane_mask(h_l)) | (h_d & lane_mask(h_l));
    return w;
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_rd = 0; m_wr = 0; m_vld = 0; h_v = 0; m_out = '0;
    end else if (sleep) begin
      m_rd = 0; m_wr = 0; m_vld = 0;
    end else begin
      if (m_wr) begin
        if (h_v) m_mem[h_a] = (m_mem[h_a] & ~lane_mask(h_l)) | (h_d & lane_mask(h_l));
        h_v = 1; h_a = m_a; h_l = m_l; h_d = din;
      end
      m_vld = m_rd;
      if (m_rd) m_out = exp_read(m_a);
      m_rd = !sel_n && wr_n;
      m_wr = !sel_n && !wr_n;
      m_a = addr;
      m_l = ~lane_wr_n;
    end
  endtask

  // kind: 0 idle, 1 read, 2 write
  task automatic cyc(input int kind, input logic [AW-1:0] a, input logic [3:0] ben,
                     input logic [35:0] d, input logic s, input logic o, input string tag);
    @(negedge clk);
    sleep = s; oe_n = o; addr = a; lane_wr_n = ben;
    sel_n = (kind == 0); wr_n = (kind != 2);
    din = pend_din;
    pend_din = (kind == 2) ? d : {$urandom, $urandom} & 36'hF_FFFF_FFFF;
    prev_dout = dout;
    @(posedge clk);
    model_edge();
    #1;
    check(tag, {35'd0, dout_drv}, {35'd0, m_vld && !oe_n && !sleep});
    if (m_vld && !oe_n && !sleep) check(tag, dout, m_out);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset drv", {35'd0, dout_drv}, 36'd0);
    @(negedge clk); rst_n = 1;

    for (int a = 0; a < DEPTH; a++) cyc(2, a[AW-1:0], 4'h0, {4'h0, 32'hA500_0000 + a}, 0, 0, "R6 init");
    cyc(2, 0, 4'hF, 36'd0, 0, 0, "R7 flush");
    cyc(0, 0, 4'hF, 0, 0, 0, "R1 idle");

    // R5 partial bypass: write only lane 1 then read immediately
    cyc(2, 3, 4'b1101, 36'h1_2345_6789, 0, 0, "R5 wr");
    cyc(1, 3, 4'hF, 0, 0, 0, "R5 rd");
    cyc(1, 3, 4'hF, 0, 0, 0, "R5 rd2");
    cyc(0, 0, 4'hF, 0, 0, 0, "R5 out");
    // R10 back-to-back reads hold constant
    cyc(1, 4, 4'hF, 0, 0, 0, "R10 a");
    cyc(1, 4, 4'hF, 0, 0, 0, "R10 b");
    cyc(1, 4, 4'hF, 0, 0, 0, "R10 c");
    check("R10 stable", dout, prev_dout);
    cyc(0, 0, 4'hF, 0, 0, 0, "R10 d");
    check("R10 stable2", dout, prev_dout);
    // R7 zero-lane write commits previous held write
    cyc(2, 5, 4'h0, 36'hF_0F0F_0F0F, 0, 0, "R7 w1");
    cyc(2, 6, 4'hF, 36'h3_3333_3333, 0, 0, "R7 w0");
    cyc(0, 0, 4'hF, 0, 0, 0, "R7 gap");
    cyc(1, 5, 4'hF, 0, 0, 0, "R7 rd5");
    cyc(1, 6, 4'hF, 0, 0, 0, "R7 rd6");
    cyc(0, 0, 4'hF, 0, 0, 0, "R7 out");
    check("R7 zero-lane no change", dout, {4'h0, 32'hA500_0006});
    // R9 output enable
    cyc(1, 7, 4'hF, 0, 0, 1, "R9 rd");
    cyc(0, 0, 4'hF, 0, 0, 1, "R9 oe high");
    // R8 sleep: write addr then sleep drops it, read sleeps too
    cyc(2, 8, 4'h0, 36'h5_5555_5555, 0, 0, "R8 wr");
    cyc(2, 9, 4'h0, 36'h6_6666_6666, 1, 0, "R8 sleep");
    cyc(1, 8, 4'hF, 0, 1, 0, "R8 sleep rd");
    cyc(0, 0, 4'hF, 0, 0, 0, "R8 wake");
    cyc(1, 8, 4'hF, 0, 0, 0, "R8 rd8");
    cyc(1, 9, 4'hF, 0, 0, 0, "R8 rd9");
    cyc(0, 0, 4'hF, 0, 0, 0, "R8 out");
    check("R8 no write in sleep", dout, {4'h0, 32'hA500_0009});
    // R11 reset empties holding register, R3/R4 via model
    cyc(2, 10, 4'h0, 36'h7_7777_7777, 0, 0, "R3 wr");
    cyc(0, 0, 4'hF, 0, 0, 0, "R3 data");
    @(negedge clk); rst_n = 0;
    @(posedge clk); model_edge(); #1;
    check("R11 reset drv mid", {35'd0, dout_drv}, 36'd0);
    @(negedge clk); rst_n = 1;
    cyc(1, 10, 4'hF, 0, 0, 0, "R11 rd");
    cyc(0, 0, 4'hF, 0, 0, 0, "R11 out");
    check("R11 array after reset", dout, {4'h0, 32'hA500_000A});

    // random mix on a small address window
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      int kind = (r < 40) ? 1 : (r < 80) ? 2 : 0;
      cyc(kind, $urandom_range(0, 7), 4'($urandom), {$urandom, $urandom} & 36'hF_FFFF_FFFF,
          $urandom_range(0, 99) < 4, $urandom_range(0, 99) < 8, "R4 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule